// File: doc/BRIEF.md
# Branch and Next-PC Unit

This combinational unit decides where a 32-bit RISC core with fixed 32-bit instruction words fetches next. It receives the current program counter, the instruction word and the two source operands the register file returns for the register indices it extracts from that word. From these it produces the next program counter, a flag that marks a taken control transfer, and a write request that saves the return address of call instructions.

Three kinds of transfer are handled. Conditional branches compare the two source registers directly, as signed or unsigned numbers, and jump relative to the PC by a 16-bit word offset. Unconditional jumps go to a register value or move relative to the PC by a 26-bit word offset. Calls do the same as the jumps and also save the address of the following instruction in a fixed link register. Any other instruction simply advances to the next sequential word.

The unit sits between register read and the fetch-address multiplexer. The return-address write goes to the register file's write arbitration.

Top module: `bru_next_pc`

## Requirements
- R1: `rs_a_idx` always equals instruction bits 25:21 and `rs_b_idx` always equals bits 20:16. The opcode is bits 31:26.
- R2: When a conditional branch is taken, `nxt_pc` equals `cur_pc` plus the sign-extended 16-bit field in bits 15:0 multiplied by 4. Offsets of either sign are supported.
- R3: Each conditional opcode compares source A with source B: 17 tests equal, 23 not equal, 18 signed greater, 19 signed greater-or-equal, 21 unsigned greater and 20 unsigned greater-or-equal. `taken` is 1 exactly when the test holds.
- R4: A conditional branch whose test fails gives `taken` = 0 and `nxt_pc` = `cur_pc` + 4.
- R5: Opcode 48 gives `taken` = 1 and `nxt_pc` = `src_a`. It does not request a link write.
- R6: Opcode 56 gives `taken` = 1 and `nxt_pc` = `cur_pc` plus the sign-extended 26-bit field in bits 25:0 multiplied by 4.
- R7: Opcode 54 targets `src_a` and opcode 62 targets the 26-bit PC-relative address of R6. Both give `taken` = 1, `link_we` = 1, `link_idx` = 29 and `link_data` = `cur_pc` + 4.
- R8: Any opcode outside 17 to 21, 23, 48, 54, 56 and 62 gives `taken` = 0, `link_we` = 0 and `nxt_pc` = `cur_pc` + 4.
- R9: A return is opcode 48 with source A index 29. It jumps to the value of register 29 and does not overwrite that register.
- R10: All address arithmetic wraps modulo 2^32. For example, a non-transfer instruction at 0xFFFFFFFC leads to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_pc | input | 32 | Address of the current instruction |
| insn | input | 32 | Current instruction word |
| src_a | input | 32 | Register value at index `rs_a_idx` |
| src_b | input | 32 | Register value at index `rs_b_idx` |
| rs_a_idx | output | 5 | Index of the first source register |
| rs_b_idx | output | 5 | Index of the second source register |
| nxt_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | Control transfer taken |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Register index for the return address |
| link_data | output | 32 | Return address value |

## Verification
The unit holds no state, so a wrong decode or comparison appears at `nxt_pc` and `taken` in the same evaluation as the instruction that triggers it. Nothing is carried forward to later instructions. The directed cases therefore aim at decisions that differ by only one bit of polarity or width. These are operands that are equal, operands whose signed and unsigned ordering disagree, offsets with the sign bit set, and the sequential address at the top of the address space. Each of these cases separates a correct result from a nearby wrong one right at the outputs.

// File: rtl/bru_next_pc.sv
module bru_next_pc #(
  parameter int XLEN     = 32,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 29
) (
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [31:0]      insn,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  output logic [IDX_W-1:0] rs_a_idx,
  output logic [IDX_W-1:0] rs_b_idx,
  output logic [XLEN-1:0]  nxt_pc,
  output logic             taken,
  output logic             link_we,
  output logic [IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]  link_data
);
  localparam logic [5:0] OP_BEQ  = 6'd17;
  localparam logic [5:0] OP_BSGT = 6'd18;
  localparam logic [5:0] OP_BSGE = 6'd19;
  localparam logic [5:0] OP_BUGE = 6'd20;
  localparam logic [5:0] OP_BUGT = 6'd21;
  localparam logic [5:0] OP_BNE  = 6'd23;
  localparam logic [5:0] OP_JR   = 6'd48;
  localparam logic [5:0] OP_CR   = 6'd54;
  localparam logic [5:0] OP_JREL = 6'd56;
  localparam logic [5:0] OP_CREL = 6'd62;

  logic [5:0]      opc;
  logic [XLEN-1:0] seq_pc, off_short, off_long;
  logic            eq, sgt, ugt, hit;

  assign opc      = insn[31:26];
  assign rs_a_idx = insn[25:21];
  assign rs_b_idx = insn[20:16];

  assign seq_pc    = cur_pc + XLEN'(4);
  assign off_short = {{(XLEN-18){insn[15]}}, insn[15:0], 2'b00};
  assign off_long  = {{(XLEN-28){insn[25]}}, insn[25:0], 2'b00};

  assign eq  = (src_a == src_b);
  assign sgt = ($signed(src_a) > $signed(src_b));
  assign ugt = (src_a > src_b);

  always_comb begin
    hit     = 1'b0;
    link_we = 1'b0;
    nxt_pc  = seq_pc;
    case (opc)
      OP_BEQ:  hit = eq;
      OP_BNE:  hit = !eq;
      OP_BSGT: hit = sgt;
      OP_BSGE: hit = sgt || eq;
      OP_BUGT: hit = ugt;
      OP_BUGE: hit = ugt || eq;
      OP_JR:   hit = 1'b1;
      OP_JREL: hit = 1'b1;
      OP_CR:   begin hit = 1'b1; link_we = 1'b1; end
      OP_CREL: begin hit = 1'b1; link_we = 1'b1; end
      default: hit = 1'b0;
    endcase
    if (hit) begin
      case (opc)
        OP_JR, OP_CR:     nxt_pc = src_a;
        OP_JREL, OP_CREL: nxt_pc = cur_pc + off_long;
        default:          nxt_pc = cur_pc + off_short;
      endcase
    end
  end

  assign taken     = hit;
  assign link_idx  = IDX_W'(LINK_REG);
  assign link_data = seq_pc;

  always_comb begin
    if (!$isunknown({cur_pc, insn, src_a, src_b})) begin
      p_seq_when_not_taken_r4: assert (taken || nxt_pc == cur_pc + XLEN'(4))
        else $error("untaken transfer left the sequential path");
      p_link_only_calls_r7: assert (!link_we || opc == OP_CR || opc == OP_CREL)
        else $error("link write outside a call");
      p_link_payload_r7: assert (!link_we || (link_data == cur_pc + XLEN'(4) && link_idx == IDX_W'(LINK_REG)))
        else $error("bad link write");
      p_reg_target_r5: assert (!(opc == OP_JR || opc == OP_CR) || (taken && nxt_pc == src_a))
        else $error("register jump target wrong");
      p_plain_op_r8: assert ((opc inside {[OP_BEQ:OP_BUGT], OP_BNE, OP_JR, OP_CR, OP_JREL, OP_CREL}) || !taken)
        else $error("plain instruction marked taken");
      p_ret_no_link_r9: assert (!(opc == OP_JR && rs_a_idx == IDX_W'(LINK_REG)) || !link_we)
        else $error("return clobbers link register");
    end
  end
endmodule

// File: tb/test_bru_next_pc.sv
module test_bru_next_pc;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] cur_pc, insn, src_a, src_b;
  logic [4:0]  rs_a_idx, rs_b_idx, link_idx;
  logic [31:0] nxt_pc, link_data;
  logic        taken, link_we;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  bru_next_pc i_bru_next_pc (
    .cur_pc(cur_pc), .insn(insn), .src_a(src_a), .src_b(src_b),
    .rs_a_idx(rs_a_idx), .rs_b_idx(rs_b_idx), .nxt_pc(nxt_pc),
    .taken(taken), .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
  );

  function automatic logic [31:0] br(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [15:0] imm);
    return {op, a, b, imm};
  endfunction

  function automatic logic [31:0] jr(input logic [5:0] op, input logic [25:0] imm);
    return {op, imm};
  endfunction

  task automatic apply(input logic [31:0] pc, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cur_pc = pc; insn = w; src_a = a; src_b = b;
    #(PERIOD/4);
  endtask

  task automatic expect_out(input string req, input logic [31:0] e_pc,
                            input logic e_tk, input logic e_we);
    n_chk++;
    if (nxt_pc !== e_pc || taken !== e_tk || link_we !== e_we) begin
      n_fail++;
      $display("FAIL %s: pc=%h taken=%b we=%b, expected pc=%h taken=%b we=%b",
               req, nxt_pc, taken, link_we, e_pc, e_tk, e_we);
    end
  endtask

  task automatic t_idle_state;
    apply(32'h0, 32'h0, 32'h0, 32'h0);
    expect_out("R8 idle", 32'h4, 1'b0, 1'b0);
  endtask

  task automatic t_fields_r1;
    apply(32'h100, br(6'd45, 5'd7, 5'd19, 16'h0), 0, 0);
    n_chk++;
    if (rs_a_idx !== 5'd7 || rs_b_idx !== 5'd19) begin
      n_fail++;
      $display("FAIL R1: idx=%0d/%0d expected 7/19", rs_a_idx, rs_b_idx);
    end
  endtask

  task automatic t_equal_r2_r3_r4;
    apply(32'h1000, br(6'd17, 5'd1, 5'd2, 16'h0010), 32'h55, 32'h55);
    expect_out("R2 beq taken fwd", 32'h1040, 1'b1, 1'b0);
    apply(32'h1000, br(6'd17, 5'd1, 5'd2, 16'h0010), 32'h55, 32'h56);
    expect_out("R4 beq not taken", 32'h1004, 1'b0, 1'b0);
    apply(32'h1000, br(6'd23, 5'd1, 5'd2, 16'hFFFF), 32'h1, 32'h2);
    expect_out("R2 bne taken back", 32'h0FFC, 1'b1, 1'b0);
    apply(32'h1000, br(6'd23, 5'd1, 5'd2, 16'hFFFF), 32'h2, 32'h2);
    expect_out("R3 bne equal", 32'h1004, 1'b0, 1'b0);
  endtask

  task automatic t_order_r3;
    apply(32'h2000, br(6'd18, 5'd1, 5'd2, 16'h0008), 32'hFFFFFFFF, 32'h1);
    expect_out("R3 sgt -1>1", 32'h2004, 1'b0, 1'b0);
    apply(32'h2000, br(6'd21, 5'd1, 5'd2, 16'h0008), 32'hFFFFFFFF, 32'h1);
    expect_out("R3 ugt max>1", 32'h2020, 1'b1, 1'b0);
    apply(32'h2000, br(6'd19, 5'd1, 5'd2, 16'h0008), 32'h80000000, 32'h80000000);
    expect_out("R3 sge equal", 32'h2020, 1'b1, 1'b0);
    apply(32'h2000, br(6'd19, 5'd1, 5'd2, 16'h0008), 32'h80000000, 32'h0);
    expect_out("R3 sge min>=0", 32'h2004, 1'b0, 1'b0);
    apply(32'h2000, br(6'd20, 5'd1, 5'd2, 16'h8000), 32'h0, 32'hFFFFFFFF);
    expect_out("R3 uge 0>=max", 32'h2004, 1'b0, 1'b0);
    apply(32'h40000, br(6'd20, 5'd1, 5'd2, 16'h8000), 32'h7, 32'h7);
    expect_out("R2 uge min offset", 32'h20000, 1'b1, 1'b0);
    apply(32'h2000, br(6'd18, 5'd1, 5'd2, 16'h0008), 32'h5, 32'h5);
    expect_out("R3 sgt equal", 32'h2004, 1'b0, 1'b0);
    apply(32'h2000, br(6'd21, 5'd1, 5'd2, 16'h0008), 32'h5, 32'h5);
    expect_out("R3 ugt equal", 32'h2004, 1'b0, 1'b0);
  endtask

  task automatic t_jumps_r5_r6_r9;
    apply(32'h3000, br(6'd48, 5'd4, 5'd0, 16'h0), 32'h20000000, 32'h0);
    expect_out("R5 reg jump", 32'h20000000, 1'b1, 1'b0);
    apply(32'h3000, br(6'd48, 5'd29, 5'd0, 16'h0), 32'h00001234, 32'h0);
    expect_out("R9 return", 32'h00001234, 1'b1, 1'b0);
    apply(32'h3000, jr(6'd56, 26'h0000100), 0, 0);
    expect_out("R6 rel jump fwd", 32'h3400, 1'b1, 1'b0);
    apply(32'h3000, jr(6'd56, 26'h3FFFFFF), 0, 0);
    expect_out("R6 rel jump back", 32'h2FFC, 1'b1, 1'b0);
  endtask

  task automatic t_calls_r7;
    apply(32'h5000, br(6'd54, 5'd3, 5'd0, 16'h0), 32'h00ABCD00, 32'h0);
    expect_out("R7 reg call", 32'h00ABCD00, 1'b1, 1'b1);
    n_chk++;
    if (link_idx !== 5'd29 || link_data !== 32'h5004) begin
      n_fail++;
      $display("FAIL R7: link %0d/%h expected 29/00005004", link_idx, link_data);
    end
    apply(32'h5000, jr(6'd62, 26'h2000000), 0, 0);
    expect_out("R7 rel call", 32'hF8005000, 1'b1, 1'b1);
    n_chk++;
    if (link_data !== 32'h5004) begin
      n_fail++;
      $display("FAIL R7: link data %h expected 00005004", link_data);
    end
  endtask

  task automatic t_plain_r8_r10;
    apply(32'h6000, br(6'd45, 5'd1, 5'd2, 16'h0040), 32'h1, 32'h1);
    expect_out("R8 add opcode", 32'h6004, 1'b0, 1'b0);
    apply(32'h6000, br(6'd22, 5'd1, 5'd2, 16'h0040), 32'h1, 32'h1);
    expect_out("R8 opcode 22", 32'h6004, 1'b0, 1'b0);
    apply(32'hFFFFFFFC, br(6'd52, 5'd1, 5'd2, 16'h0), 0, 0);
    expect_out("R10 wrap", 32'h0, 1'b0, 1'b0);
    apply(32'hFFFFFFF0, br(6'd17, 5'd1, 5'd2, 16'h0008), 32'h3, 32'h3);
    expect_out("R10 branch wrap", 32'h00000010, 1'b1, 1'b0);
  endtask

  initial begin
    cur_pc = '0; insn = '0; src_a = '0; src_b = '0;
    fork
      begin
        t_idle_state;
        t_fields_r1;
        t_equal_r2_r3_r4;
        t_order_r3;
        t_jumps_r5_r6_r9;
        t_calls_r7;
        t_plain_r8_r10;
      end
      begin
        #(PERIOD * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule